// File: doc/BRIEF.md
# Bit-Addressed Serial I/O Port Target

This block is the peripheral end of a bit-serial I/O bus. On this bus the processor moves a single bit per access, and that bit travels on an address pin rather than on a data bus. The I/O space is a separate region addressed in single bits. The lowest address line never selects a location. During an output cycle it carries the bit being written, and a strobe that the processor pulses during the I/O cycle commits that bit. For reads, the processor samples one dedicated return line, which the port drives with the addressed bit.

The port decodes its own base address from the upper address lines. It uses the three lines just above the data line to pick one of eight bits. It keeps an eight-bit output register, updated one bit per strobe. It also returns one selected bit of an eight-bit input vector. The strobe comes from outside the clock domain, so the block synchronises it and acts on its rising edge. A block move is issued as a run of consecutive bit addresses, each with its own strobe, and this builds up a whole byte in the register.

Top module: `bitport_target`

## Requirements
- R1: Asserting `rst_n` low clears all bits of `out_reg` to 0.
- R2: An access is a hit when `io_cyc` is 1 and `cpu_addr[15:4]` equals the base parameter (default 12'h0C8). On a rising edge of `io_strobe` during a hit, bit `cpu_addr[3:1]` of `out_reg` takes the value of `cpu_addr[0]`. The new value is visible no later than the third rising clock edge after the strobe rises.
- R3: During a hit, `rd_bit` equals `in_vec[cpu_addr[3:1]]`, with no clock delay.
- R4: When the access is not a hit, `rd_bit` is 0.
- R5: `out_reg` never changes in more than one bit from one clock cycle to the next.
- R6: A strobe edge that arrives while the upper address does not match, or while `io_cyc` is 0, leaves `out_reg` unchanged.
- R7: Only the rising edge of the strobe writes. Holding `io_strobe` high while the address changes writes no further bit, and with the strobe low `out_reg` holds its value.
- R8: A run of consecutive bit addresses, each with its own strobe pulse, writes each addressed bit in turn, so that eight accesses load a full byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_addr | input | 16 | Processor address: [0] carries the write bit, [3:1] select the bit, [15:4] are compared to the base |
| io_cyc | input | 1 | High while the processor runs an I/O-space cycle |
| io_strobe | input | 1 | Asynchronous bit-write strobe |
| in_vec | input | 8 | Input bits offered for reading |
| out_reg | output | 8 | Bit-written output register |
| rd_bit | output | 1 | Selected input bit returned to the processor |

## Verification
On every cycle, the assertions check the read path: a hit returns the indexed input bit and a miss returns 0. They also check that the register changes in at most one bit per cycle, and that it holds across a miss, an idle I/O cycle or a quiet strobe. The value a write leaves behind depends on an address seen several cycles earlier through the synchroniser. Only the bench scenarios show that value, along with byte build-up from consecutive addresses, single writes under a held strobe, and clearing by reset in the middle of a run.

// File: rtl/bitport_pkg.sv
package bitport_pkg;
  localparam int unsigned DEF_ABUS_W = 16;
  localparam int unsigned DEF_PORT_W = 8;
  localparam int unsigned DEF_SYNC_N = 2;

  // number of select bits needed to index a port of given width
  function automatic int unsigned sel_bits(input int unsigned w);
    int unsigned n;
    n = 0;
    while ((1 << n) < w) n++;
    return (n == 0) ? 1 : n;
  endfunction
endpackage

// File: rtl/bitport_strobe_sync.sv
module bitport_strobe_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic strobe_rise
);
  logic [SYNC_N-1:0] chain_q;
  logic [SYNC_N-1:0] chain_d;
  logic              last_q;
  logic              last_d;

  generate
    for (genvar i = 0; i < SYNC_N; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = strobe_async;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  assign last_d = chain_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign strobe_rise = chain_q[SYNC_N-1] & ~last_q;
endmodule

// File: rtl/bitport_decode.sv
module bitport_decode #(
  parameter int unsigned ABUS_W = 16,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned TAG_W  = ABUS_W - SEL_W - 1,
  parameter logic [TAG_W-1:0] BASE_TAG = '0
) (
  input  logic [ABUS_W-1:0] cpu_addr,
  input  logic              io_cyc,
  output logic              hit,
  output logic [SEL_W-1:0]  sel,
  output logic              wbit
);
  logic [TAG_W-1:0] tag;

  always_comb begin
    tag  = cpu_addr[ABUS_W-1:SEL_W+1];
    sel  = cpu_addr[SEL_W:1];
    wbit = cpu_addr[0];
    hit  = io_cyc && (tag == BASE_TAG);
  end
endmodule

// File: rtl/bitport_bitreg.sv
module bitport_bitreg #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_bit,
  output logic [PORT_W-1:0] bits_q
);
  logic [PORT_W-1:0] bits_d;
  logic [PORT_W-1:0] bit_en;

  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
      always_comb begin
        bit_en[i] = wr_en && (wr_sel == SEL_W'(i));
        bits_d[i] = bit_en[i] ? wr_bit : bits_q[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (|bit_en) begin
      bits_q <= bits_d;
    end
  end
endmodule

// File: rtl/bitport_rdmux.sv
module bitport_rdmux #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [PORT_W-1:0] in_vec,
  input  logic [SEL_W-1:0]  sel,
  input  logic              hit,
  output logic              rd_bit
);
  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < PORT_W; i++) begin
      if (sel == SEL_W'(i)) picked = in_vec[i];
    end
    rd_bit = hit & picked;
  end
endmodule

// File: rtl/bitport_target.sv
module bitport_target #(
  parameter int unsigned ABUS_W = bitport_pkg::DEF_ABUS_W,
  parameter int unsigned PORT_W = bitport_pkg::DEF_PORT_W,
  parameter int unsigned SYNC_N = bitport_pkg::DEF_SYNC_N,
  parameter int unsigned BASE   = 'h0C8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ABUS_W-1:0] cpu_addr,
  input  logic              io_cyc,
  input  logic              io_strobe,
  input  logic [PORT_W-1:0] in_vec,
  output logic [PORT_W-1:0] out_reg,
  output logic              rd_bit
);
  localparam int unsigned SEL_W = bitport_pkg::sel_bits(PORT_W);
  localparam int unsigned TAG_W = ABUS_W - SEL_W - 1;
  localparam logic [TAG_W-1:0] BASE_TAG = TAG_W'(BASE);

  logic             hit;
  logic [SEL_W-1:0] sel;
  logic             wbit;
  logic             rise;

  bitport_strobe_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_async(io_strobe), .strobe_rise(rise)
  );

  bitport_decode #(.ABUS_W(ABUS_W), .SEL_W(SEL_W), .TAG_W(TAG_W), .BASE_TAG(BASE_TAG)) u_dec (
    .cpu_addr(cpu_addr), .io_cyc(io_cyc), .hit(hit), .sel(sel), .wbit(wbit)
  );

  bitport_bitreg #(.PORT_W(PORT_W), .SEL_W(SEL_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(rise & hit), .wr_sel(sel), .wr_bit(wbit),
    .bits_q(out_reg)
  );

  bitport_rdmux #(.PORT_W(PORT_W), .SEL_W(SEL_W)) u_rd (
    .in_vec(in_vec), .sel(sel), .hit(hit), .rd_bit(rd_bit)
  );
endmodule

// File: rtl/bitport_target_chk.sv
module bitport_target_chk #(
  parameter int unsigned ABUS_W = 16,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned BASE   = 'h0C8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ABUS_W-1:0] cpu_addr,
  input logic              io_cyc,
  input logic              io_strobe,
  input logic [PORT_W-1:0] in_vec,
  input logic [PORT_W-1:0] out_reg,
  input logic              rd_bit
);
  localparam int unsigned SEL_W = bitport_pkg::sel_bits(PORT_W);
  localparam int unsigned TAG_W = ABUS_W - SEL_W - 1;
  localparam logic [TAG_W-1:0] BASE_TAG = TAG_W'(BASE);

  logic port_hit;
  assign port_hit = io_cyc && (cpu_addr[ABUS_W-1:SEL_W+1] == BASE_TAG);

  // R1: while reset is held, the register reads zero
  always @(posedge clk) begin
    if (!rst_n) p_reset_clear_r1 : assert (out_reg == '0);
  end

  // R3
  p_read_select_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    port_hit |-> rd_bit == in_vec[cpu_addr[SEL_W:1]]);

  // R4
  p_read_miss_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    !port_hit |-> !rd_bit);

  // R5
  p_one_bit_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(out_reg ^ $past(out_reg)) <= 1);

  // R6
  p_miss_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    !port_hit |=> $stable(out_reg));

  // R7
  p_quiet_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (!io_strobe && !$past(io_strobe)) |=> $stable(out_reg));
endmodule

bind bitport_target bitport_target_chk #(
  .ABUS_W(ABUS_W), .PORT_W(PORT_W), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .io_cyc(io_cyc),
  .io_strobe(io_strobe), .in_vec(in_vec), .out_reg(out_reg), .rd_bit(rd_bit)
);

// File: tb/tb_bitport_target.sv
`timescale 1ns/1ps
module tb_bitport_target;
  localparam logic [11:0] BASE = 12'h0C8;

  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        io_cyc;
  logic        io_strobe;
  logic [7:0]  in_vec;
  logic [7:0]  out_reg;
  logic        rd_bit;

  int n_chk;
  int n_fail;

  bitport_target #(.ABUS_W(16), .PORT_W(8), .SYNC_N(2), .BASE(32'(BASE))) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .io_cyc(io_cyc),
    .io_strobe(io_strobe), .in_vec(in_vec), .out_reg(out_reg), .rd_bit(rd_bit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // table entry: {hit, sel[2:0], data bit, expected out_reg[7:0]}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 3'd0, 1'b1, 8'h01},
    {1'b1, 3'd1, 1'b1, 8'h03},
    {1'b1, 3'd7, 1'b1, 8'h83},
    {1'b0, 3'd2, 1'b1, 8'h83},
    {1'b1, 3'd0, 1'b0, 8'h82},
    {1'b1, 3'd5, 1'b1, 8'hA2},
    {1'b1, 3'd7, 1'b0, 8'h22},
    {1'b0, 3'd5, 1'b0, 8'h22}
  };

  function automatic logic [15:0] mk_addr(input logic hit, input logic [2:0] sel,
                                          input logic d);
    return {hit ? BASE : (BASE ^ 12'h001), sel, d};
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_write(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
    io_strobe = 1'b1;
    repeat (5) @(negedge clk);
    io_strobe = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b1;
    cpu_addr = '0;
    io_cyc = 1'b0;
    io_strobe = 1'b0;
    in_vec = 8'h00;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check8("R1 reset value", out_reg, 8'h00);
    rst_n = 1'b1;
    io_cyc = 1'b1;

    // vector table: R2 writes on hit, R6 misses hold
    for (int i = 0; i < NV; i++) begin
      pulse_write(mk_addr(VEC[i][12], VEC[i][11:9], VEC[i][8]));
      check8(VEC[i][12] ? "R2 hit write" : "R6 miss hold", out_reg, VEC[i][7:0]);
    end

    // R6: strobe outside an I/O cycle
    io_cyc = 1'b0;
    pulse_write(mk_addr(1'b1, 3'd3, 1'b1));
    check8("R6 no io cycle", out_reg, 8'h22);
    io_cyc = 1'b1;

    // R7: held strobe writes once
    @(negedge clk);
    cpu_addr = mk_addr(1'b1, 3'd3, 1'b1);
    @(negedge clk);
    io_strobe = 1'b1;
    repeat (5) @(negedge clk);
    check8("R7 first edge", out_reg, 8'h2A);
    cpu_addr = mk_addr(1'b1, 3'd4, 1'b1);
    repeat (6) @(negedge clk);
    check8("R7 held strobe", out_reg, 8'h2A);
    io_strobe = 1'b0;
    repeat (5) @(negedge clk);
    check8("R7 after release", out_reg, 8'h2A);

    // R8: consecutive bit addresses load a byte
    for (int b = 0; b < 8; b++) begin
      logic [7:0] pat;
      pat = 8'h5A;
      pulse_write(mk_addr(1'b1, 3'(b), pat[b]));
    end
    check8("R8 byte loaded", out_reg, 8'h5A);

    // R3 / R4: reads
    in_vec = 8'hC5;
    for (int s = 0; s < 8; s++) begin
      logic [7:0] iv;
      iv = 8'hC5;
      @(negedge clk);
      cpu_addr = mk_addr(1'b1, 3'(s), 1'b0);
      @(negedge clk);
      check8("R3 read hit", {7'b0, rd_bit}, {7'b0, iv[s]});
    end
    @(negedge clk);
    cpu_addr = mk_addr(1'b0, 3'd0, 1'b0);
    @(negedge clk);
    check8("R4 read miss", {7'b0, rd_bit}, 8'h00);
    cpu_addr = mk_addr(1'b1, 3'd2, 1'b0);
    io_cyc = 1'b0;
    @(negedge clk);
    check8("R4 read idle", {7'b0, rd_bit}, 8'h00);
    io_cyc = 1'b1;
    in_vec = 8'h3A;
    @(negedge clk);
    check8("R3 input change", {7'b0, rd_bit}, 8'h00);
    cpu_addr = mk_addr(1'b1, 3'd3, 1'b0);
    @(negedge clk);
    check8("R3 input bit3", {7'b0, rd_bit}, 8'h01);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check8("R1 reset mid-run", out_reg, 8'h00);
    rst_n = 1'b1;
    pulse_write(mk_addr(1'b1, 3'd6, 1'b1));
    check8("R2 write after reset", out_reg, 8'h40);

    finish_run();
  end
endmodule